// File: doc/BRIEF.md
# Dual Tick Timer (One-Shot and Periodic)

This block holds two 32-bit tick timers behind a word-wide register interface. One timer fires once and then disarms itself. The other fires again and again at a fixed interval. A single tick-enable input advances both timers. Each timer has two registers:

- a programmed-value register, which can be read and written;
- a remaining-ticks register, which is read-only.

Each timer also drives its own expiry pulse.

Software arms a timer by writing a nonzero tick count and disarms it by writing zero. Register data crosses the bus with the most significant byte in the lowest-addressed byte lane. Only full-word accesses are honoured. A narrower access to a mapped register raises an error flag and leaves the state unchanged.

Top module: `dual_tick_timer`

## Requirements
- R1: After reset, all four registers read 0 and both expiry outputs are low.
- R2: Registers are mapped as follows:
  - offset 0x20: one-shot value, read/write;
  - offset 0x24: one-shot remaining ticks, read-only;
  - offset 0x28: periodic value, read/write;
  - offset 0x2C: periodic remaining ticks, read-only.
  Writes to the remaining-ticks offsets or to any unmapped offset change nothing. Reads of unmapped offsets return 0.
- R3: An access to a mapped offset with `size_i` not equal to 4 asserts `err_o` in the same cycle. It updates no state, and `rdata_o` reads 0.
- R4: Bus byte lane k (bits 8k+7..8k) carries address byte k. The register value's bits 31..24 travel in lane 0, so value = {lane0, lane1, lane2, lane3}. This applies to both `wdata_i` and `rdata_o`.
- R5: A nonzero write loads both the value and the remaining count with the written value from the next cycle on. Any pending expiry is cancelled.
- R6: A zero write disarms the timer. Its remaining register reads 0, and no expiry pulse follows until it is rewritten.
- R7: Reading a value register returns the last value written to it, apart from the clearing on one-shot expiry (R9).
- R8: On each cycle with `tick_i` high and no write to that timer, an armed timer's remaining count drops by one. Without a tick, the count holds.
- R9: On the tick on which the one-shot's remaining count is 1, `oneshot_irq_o` is high for that cycle. From the next cycle, both of the one-shot's registers read 0.
- R10: On the tick on which the periodic remaining count is 1, `periodic_irq_o` is high for that cycle. The remaining count reloads the programmed value, so a value of 1 fires on every tick.
- R11: A write to a timer in the same cycle as a tick takes priority. That tick neither decrements the new value nor produces an expiry pulse for that timer.
- R12: Read data is combinational. It is valid in the same cycle as `req_i` with `we_i` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Tick enable shared by both timers |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 6 | Byte offset of the access |
| size_i | input | 3 | Access size in bytes |
| wdata_i | input | 32 | Write data, in big-endian lane order |
| rdata_o | output | 32 | Read data, in big-endian lane order |
| err_o | output | 1 | Bad-size access to a mapped register |
| oneshot_irq_o | output | 1 | One-cycle pulse on one-shot expiry |
| periodic_irq_o | output | 1 | One-cycle pulse on each periodic expiry |

## Verification
The assertions check the following on every cycle:
- the countdown step on each tick, and the hold without one;
- the load that follows a write, and write priority over a tick;
- the post-expiry state, which is a clear for the one-shot and a reload for the periodic timer;
- that an errored access never reaches a timer.

Only the bench's scenarios can show that the byte-lane order matches the requirement, that the address map is correct, and that a disarmed timer stays silent over many ticks. The same holds for whole expiry sequences, such as a period of 1 firing on every tick.

// File: rtl/dual_tick_timer_pkg.sv
package dual_tick_timer_pkg;
  localparam int unsigned AW        = 6;
  localparam int unsigned DW        = 32;
  localparam int unsigned NTIMER    = 2;
  localparam logic [AW-1:0] BASE_OFF = 6'h20;
  localparam int unsigned STRIDE    = 8;

  function automatic logic [DW-1:0] lane_swap(input logic [DW-1:0] x);
    logic [DW-1:0] y;
    for (int b = 0; b < DW/8; b++) y[8*b +: 8] = x[DW-8-8*b +: 8];
    return y;
  endfunction
endpackage

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int unsigned W        = 32,
  parameter bit          PERIODIC = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] val_o,
  output logic [W-1:0] rem_o,
  output logic         fire_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] val_q, rem_q;
  logic [W-1:0] val_exp, rem_exp;

  assign fire_o = tick_i && !wr_i && (rem_q == ONE);

  generate
    if (PERIODIC) begin : g_reload
      assign val_exp = val_q;
      assign rem_exp = val_q;
    end else begin : g_oneshot
      assign val_exp = '0;
      assign rem_exp = '0;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= '0;
      rem_q <= '0;
    end else if (wr_i) begin
      val_q <= wdata_i;
      rem_q <= wdata_i;
    end else if (fire_o) begin
      val_q <= val_exp;
      rem_q <= rem_exp;
    end else if (tick_i && rem_q != '0) begin
      rem_q <= rem_q - ONE;
    end
  end

  assign val_o = val_q;
  assign rem_o = rem_q;

  a_r5_write_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (rem_o == $past(wdata_i)) && (val_o == $past(wdata_i)));
  a_r11_write_beats_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> !fire_o);
  a_r8_tick_decrements: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_i && rem_o > ONE) |=> rem_o == $past(rem_o) - ONE);
  a_r8_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_i) |=> $stable(rem_o) && $stable(val_o));
  a_r6_disarmed_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rem_o == '0) |-> !fire_o);
  if (PERIODIC) begin : g_a_per
    a_r10_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fire_o |=> (rem_o == $past(val_o)) && $stable(val_o));
  end else begin : g_a_one
    a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fire_o |=> (rem_o == '0) && (val_o == '0));
  end
endmodule

// File: rtl/timer_regif.sv
module timer_regif
  import dual_tick_timer_pkg::*;
#(
  parameter int unsigned N = NTIMER
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [2:0]          size_i,
  input  logic [DW-1:0]       wdata_i,
  input  logic [N-1:0][DW-1:0] val_i,
  input  logic [N-1:0][DW-1:0] rem_i,
  output logic [N-1:0]        wr_o,
  output logic [DW-1:0]       wval_o,
  output logic [DW-1:0]       rdata_o,
  output logic                err_o
);
  localparam logic [2:0] FULL = 3'(DW/8);

  logic [N-1:0] hit_val, hit_rem;
  logic         full_ok, any_hit;
  logic [DW-1:0] rd;

  for (genvar i = 0; i < N; i++) begin : g_dec
    assign hit_val[i] = addr_i == AW'(BASE_OFF + STRIDE*i);
    assign hit_rem[i] = addr_i == AW'(BASE_OFF + STRIDE*i + 4);
  end

  assign full_ok = size_i == FULL;
  assign any_hit = |{hit_val, hit_rem};
  assign err_o   = req_i && any_hit && !full_ok;
  assign wr_o    = (req_i && we_i && full_ok) ? hit_val : '0;
  assign wval_o  = lane_swap(wdata_i);

  always_comb begin
    rd = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_val[i]) rd = val_i[i];
      if (hit_rem[i]) rd = rem_i[i];
    end
    rdata_o = (req_i && !we_i && full_ok) ? lane_swap(rd) : '0;
  end

  a_r3_err_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (wr_o == '0) && (rdata_o == '0));
  a_r2_single_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_o));
endmodule

// File: rtl/dual_tick_timer.sv
module dual_tick_timer
  import dual_tick_timer_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [2:0]    size_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          err_o,
  output logic          oneshot_irq_o,
  output logic          periodic_irq_o
);
  logic [NTIMER-1:0][DW-1:0] val, rem;
  logic [NTIMER-1:0]         wr, fire;
  logic [DW-1:0]             wval;

  timer_regif #(.N(NTIMER)) u_regif (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .size_i, .wdata_i,
    .val_i(val), .rem_i(rem), .wr_o(wr), .wval_o(wval),
    .rdata_o, .err_o
  );

  // timer 0 one-shot, timer 1 periodic
  for (genvar i = 0; i < NTIMER; i++) begin : g_tmr
    tick_timer #(.W(DW), .PERIODIC(i == 1)) u_tmr (
      .clk_i, .rst_ni, .tick_i,
      .wr_i(wr[i]), .wdata_i(wval),
      .val_o(val[i]), .rem_o(rem[i]), .fire_o(fire[i])
    );
  end

  assign oneshot_irq_o  = fire[0];
  assign periodic_irq_o = fire[1];
endmodule

// File: tb/dual_tick_timer_test.sv
module dual_tick_timer_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, tick = 0, req = 0, we = 0;
  logic [5:0] addr = 0;
  logic [2:0] size = 4;
  logic [31:0] wdata = 0, rdata;
  logic err, irq0, irq1;
  int total = 0, bad = 0;
  bit done = 0;
  logic [31:0] mval [2];
  logic [31:0] mrem [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_tick_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .req_i(req), .we_i(we),
    .addr_i(addr), .size_i(size), .wdata_i(wdata), .rdata_o(rdata),
    .err_o(err), .oneshot_irq_o(irq0), .periodic_irq_o(irq1)
  );

  function automatic logic [31:0] sw(input logic [31:0] x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // one cycle: drive, compare against model, then advance model on the edge
  task automatic step(input string tag, input bit r, input bit w, input logic [5:0] a,
                      input logic [2:0] s, input logic [31:0] v, input bit t);
    logic [31:0] erd, sel;
    bit mapped, wr0, wr1, e0, e1;
    @(negedge clk);
    req = r; we = w; addr = a; size = s; wdata = sw(v); tick = t;
    #1;
    mapped = (a == 6'h20) || (a == 6'h24) || (a == 6'h28) || (a == 6'h2C);
    wr0 = r && w && s == 4 && a == 6'h20;
    wr1 = r && w && s == 4 && a == 6'h28;
    sel = 0;
    case (a)
      6'h20: sel = mval[0];
      6'h24: sel = mrem[0];
      6'h28: sel = mval[1];
      6'h2C: sel = mrem[1];
      default: sel = 0;
    endcase
    erd = (r && !w && s == 4) ? sw(sel) : 0;
    e0 = t && !wr0 && mrem[0] == 1;
    e1 = t && !wr1 && mrem[1] == 1;
    chk(tag, "rdata", rdata, erd);
    chk(tag, "err", {31'd0, err}, {31'd0, r && mapped && s != 4});
    chk(tag, "oneshot_irq", {31'd0, irq0}, {31'd0, e0});
    chk(tag, "periodic_irq", {31'd0, irq1}, {31'd0, e1});
    @(posedge clk);
    if (wr0) begin mval[0] = v; mrem[0] = v; end
    else if (e0) begin mval[0] = 0; mrem[0] = 0; end
    else if (t && mrem[0] != 0) mrem[0] = mrem[0] - 1;
    if (wr1) begin mval[1] = v; mrem[1] = v; end
    else if (e1) mrem[1] = mval[1];
    else if (t && mrem[1] != 0) mrem[1] = mrem[1] - 1;
  endtask

  task automatic wr(input string tag, input logic [5:0] a, input logic [31:0] v, input bit t);
    step(tag, 1, 1, a, 4, v, t);
  endtask
  task automatic rd(input string tag, input logic [5:0] a);
    step(tag, 1, 0, a, 4, 0, 0);
  endtask
  task automatic ticks(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag, 0, 0, 0, 4, 0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL R8 watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    mval[0] = 0; mval[1] = 0; mrem[0] = 0; mrem[1] = 0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    // R1 reset state
    rd("R1", 6'h20); rd("R1", 6'h24); rd("R1", 6'h28); rd("R1", 6'h2C);
    // R4 lane order: value 0x00000103 readback
    wr("R4", 6'h20, 32'h0000_0103, 0);
    @(negedge clk); req = 1; we = 0; addr = 6'h20; size = 4; tick = 0; #1;
    chk("R4", "raw_lanes", rdata, 32'h0301_0000);
    rd("R7", 6'h20);
    wr("R6", 6'h20, 0, 0);
    ticks("R6", 3);
    rd("R6", 6'h24);
    // R3 bad sizes
    step("R3", 1, 1, 6'h20, 2, 7, 0);
    step("R3", 1, 0, 6'h20, 1, 0, 0);
    rd("R3", 6'h20); rd("R3", 6'h24);
    // R2 read-only and unmapped offsets
    wr("R2", 6'h24, 9, 0); wr("R2", 6'h30, 9, 0);
    rd("R2", 6'h24); rd("R2", 6'h30); rd("R2", 6'h20);
    // R5 rearm cancels pending
    wr("R5", 6'h20, 4, 0); ticks("R5", 2);
    wr("R5", 6'h20, 6, 1); rd("R5", 6'h24);
    // R9 one-shot expiry, then both regs zero
    ticks("R9", 6); rd("R9", 6'h20); rd("R9", 6'h24); ticks("R9", 4);
    // R10 periodic reload
    wr("R10", 6'h28, 3, 0); ticks("R10", 7);
    rd("R10", 6'h2C); rd("R7", 6'h28);
    wr("R10", 6'h28, 1, 0); ticks("R10", 4);
    // R11 write on the expiring tick
    wr("R11", 6'h20, 1, 0);
    wr("R11", 6'h20, 5, 1); rd("R11", 6'h24);
    wr("R11", 6'h28, 2, 1); rd("R11", 6'h2C);
    // R6 disarm periodic mid-count
    ticks("R6", 1); wr("R6", 6'h28, 0, 0); ticks("R6", 8);
    rd("R6", 6'h2C);
    // R8 / R12 mixed traffic
    for (int i = 0; i < 3000; i++) begin
      int k;
      k = $urandom_range(0, 19);
      if (k == 0) wr("R8", 6'h20, $urandom_range(0, 8), $urandom_range(0, 1));
      else if (k == 1) wr("R8", 6'h28, $urandom_range(0, 5), $urandom_range(0, 1));
      else if (k < 6) begin
        logic [5:0] a;
        a = 6'h20 + 6'($urandom_range(0, 3) * 4);
        step("R12", 1, 0, a, 4, 0, $urandom_range(0, 1));
      end else step("R8", 0, 0, 0, 4, 0, $urandom_range(0, 1));
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule